// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

The block produces the column addresses of one SDRAM read or write burst, one per clock. A start strobe captures a start column, a burst length code, an ordering select and an auto-precharge request. From the next clock on, the block presents a new column each cycle with a valid flag, until the programmed length is used up or a burst-stop input cuts the burst short.

Fixed bursts of 2, 4 and 8 step only the low column bits and wrap inside their aligned block. The order is either linear (add the beat count) or interleaved (XOR the beat count into the start column's low bits). A full-page burst walks linearly through all 256 columns of the page. It wraps from the top column to column 0 and runs until it is stopped.

When auto precharge was requested, an end flag marks the final column of a fixed burst, so that a row-close sequence can be triggered. The block can sit inside a memory model or in front of a controller's data path. Row handling, data and CAS latency lie outside it.

Top module: `sdram_bseq`

## Requirements
- R1: While rst_ni is low and after its release with no start, valid_o and last_o are 0.
- R2: A start_i sampled at a rising edge makes valid_o 1 after that edge, and the first column shown is start_col_i.
- R3: len_code_i selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and any code with bit 2 set gives a full page. An unstopped fixed burst holds valid_o high for exactly that many cycles.
- R4: In linear order (order_i = 0), beat k of a fixed burst of length L shows the start column with its low log2(L) bits replaced by (start + k) mod L. The upper bits do not change during the burst.
- R5: In interleaved order (order_i = 1), beat k of a fixed burst of length L has its low log2(L) bits equal to the start column's low bits XOR k, and its upper bits equal to those of the start column.
- R6: A full-page burst shows (start + k) mod 256 at beat k, so it wraps from 255 to 0. order_i has no effect on it, and it continues until stopped or restarted.
- R7: stop_i high at a rising edge during a burst, with start_i low, makes valid_o 0 from that edge on. stop_i while idle has no effect.
- R8: last_o is 1 exactly on the final beat of a fixed burst started with auto_pre_i = 1. It is never 1 for a full-page burst or when auto_pre_i was 0 at start.
- R9: start_i during an active burst abandons it: the next cycle shows the new start column, and the new burst runs its full new length.
- R10: When start_i and stop_i are high at the same edge, the start wins and the new burst begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start a new burst with the inputs below |
| start_col_i | input | 8 | Start column |
| len_code_i | input | 3 | Burst length code (see R3) |
| order_i | input | 1 | 0 linear, 1 interleaved |
| auto_pre_i | input | 1 | Request an end flag on the last beat |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | 8 | Current column address |
| valid_o | output | 1 | col_o holds a beat of the burst |
| last_o | output | 1 | Final beat of an auto-precharge burst |

## Verification
The beat counter, the latched mask and the latched mode all show up in col_o on the very next beat. A wrong count, a wrong mask or a lost ordering bit therefore gives a wrong column within one cycle of the burst start, or at the first wrap inside the aligned block. A faulty end comparison or stop path shows as valid_o lasting one cycle too long or too short, or as a misplaced last_o. A bench that compares every beat against computed columns catches such faults on the cycle they occur. Full-page bursts started near column 255 expose a wrong wrap width at once.

// File: rtl/sdram_bseq_pkg.sv
package sdram_bseq_pkg;
  localparam int unsigned LEN_CODE_W = 3;
  localparam int unsigned FIX_LOG2_MAX = 3;

  typedef struct packed {
    logic full;
    logic inter;
    logic auto_pre;
  } burst_cfg_t;
endpackage

// File: rtl/sdram_bseq_decode.sv
module sdram_bseq_decode
  import sdram_bseq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  input  logic                  auto_pre_i,
  output logic [COL_W-1:0]      mask_o,
  output burst_cfg_t            cfg_o
);
  logic full_w;
  assign full_w = len_code_i[LEN_CODE_W-1];

  // interleave is undefined for full page: fall back to linear
  assign cfg_o.full     = full_w;
  assign cfg_o.inter    = order_i & ~full_w;
  assign cfg_o.auto_pre = auto_pre_i;

  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    if (b < FIX_LOG2_MAX) begin : g_low
      assign mask_o[b] = full_w | (2'(b) < len_code_i[1:0]);
    end else begin : g_high
      assign mask_o[b] = full_w;
    end
  end
endmodule

// File: rtl/sdram_bseq_ctrl.sv
module sdram_bseq_ctrl
  import sdram_bseq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [COL_W-1:0] mask_i,
  input  burst_cfg_t       cfg_i,
  output logic             active_o,
  output logic             last_o,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] cnt_o,
  output logic [COL_W-1:0] mask_o,
  output burst_cfg_t       cfg_o
);
  logic             active_q;
  logic [COL_W-1:0] cnt_q, base_q, mask_q;
  burst_cfg_t       cfg_q;
  logic             at_end;

  // mask equals length-1 for fixed bursts
  assign at_end = (cnt_q == mask_q) & ~cfg_q.full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      base_q   <= '0;
      mask_q   <= '0;
      cfg_q    <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      cnt_q    <= '0;
      base_q   <= start_col_i;
      mask_q   <= mask_i;
      cfg_q    <= cfg_i;
    end else if (active_q) begin
      if (stop_i || at_end) active_q <= 1'b0;
      else                  cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign active_o = active_q;
  assign last_o   = active_q & at_end & cfg_q.auto_pre;
  assign base_o   = base_q;
  assign cnt_o    = cnt_q;
  assign mask_o   = mask_q;
  assign cfg_o    = cfg_q;

  assert_start_opens_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (active_q && cnt_q == '0));
  assert_start_beats_stop_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && stop_i) |=> active_q);
  assert_stop_closes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && stop_i && !start_i) |=> !active_q);
  assert_fixed_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && at_end && !start_i) |=> !active_q);
  assert_last_in_burst_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> (active_q && !cfg_q.full));
endmodule

// File: rtl/sdram_bseq_addr.sv
module sdram_bseq_addr #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] cnt_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             inter_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq;
  assign seq = inter_i ? (base_i ^ cnt_i) : (base_i + cnt_i);

  // masked bits step, the rest hold the aligned block
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? seq[b] : base_i[b];
  end
endmodule

// File: rtl/sdram_bseq.sv
module sdram_bseq
  import sdram_bseq_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [COL_W-1:0]      start_col_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  input  logic                  auto_pre_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  valid_o,
  output logic                  last_o
);
  logic [COL_W-1:0] mask_d, mask_q, base_q, cnt_q;
  burst_cfg_t       cfg_d, cfg_q;

  sdram_bseq_decode #(.COL_W(COL_W)) u_decode (
    .len_code_i (len_code_i),
    .order_i    (order_i),
    .auto_pre_i (auto_pre_i),
    .mask_o     (mask_d),
    .cfg_o      (cfg_d)
  );

  sdram_bseq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .stop_i      (stop_i),
    .start_col_i (start_col_i),
    .mask_i      (mask_d),
    .cfg_i       (cfg_d),
    .active_o    (valid_o),
    .last_o      (last_o),
    .base_o      (base_q),
    .cnt_o       (cnt_q),
    .mask_o      (mask_q),
    .cfg_o       (cfg_q)
  );

  sdram_bseq_addr #(.COL_W(COL_W)) u_addr (
    .base_i  (base_q),
    .cnt_i   (cnt_q),
    .mask_i  (mask_q),
    .inter_i (cfg_q.inter),
    .col_o   (col_o)
  );

  assert_first_col_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (col_o == $past(start_col_i)));
  assert_block_fixed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !start_i && !stop_i && !last_o) |=>
      (!valid_o || ((col_o & ~mask_q) == ($past(col_o) & ~mask_q))));
  assert_page_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && cfg_q.full && col_o == '1 && !stop_i && !start_i) |=>
      (valid_o && col_o == '0));
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> !last_o);
endmodule

// File: tb/sdram_bseq_test.sv
module sdram_bseq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] scol = '0;
  logic [2:0] lcode = '0;
  logic       ord = 1'b0;
  logic       ap = 1'b0;
  logic       stp = 1'b0;
  logic [7:0] col;
  logic       vld;
  logic       lst;
  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  sdram_bseq uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_col_i(scol),
    .len_code_i(lcode), .order_i(ord), .auto_pre_i(ap), .stop_i(stp),
    .col_o(col), .valid_o(vld), .last_o(lst)
  );

  function automatic int blen(input logic [2:0] c);
    return c[2] ? 256 : (1 << c[1:0]);
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] c,
                                          input logic il, input int k);
    logic [7:0] m, lo;
    m  = 8'(blen(c) - 1);
    lo = (il && !c[2]) ? (s ^ 8'(k)) : (s + 8'(k));
    return (s & ~m) | (lo & m);
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stop_k < 0: run to the end (fixed bursts only)
  task automatic burst(input logic [7:0] s, input logic [2:0] c, input logic il,
                       input logic a, input int stop_k, input string req);
    int n;
    n = blen(c);
    @(negedge clk);
    start = 1'b1; scol = s; lcode = c; ord = il; ap = a; stp = 1'b0;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 100000; k++) begin
      chk(vld == 1'b1, {req, " valid"}, int'(vld), 1);
      chk(col == exp_col(s, c, il, k), {req, " col"}, int'(col), int'(exp_col(s, c, il, k)));
      chk(lst == (a && !c[2] && k == n - 1), {req, " R8 last"}, int'(lst),
          int'(a && !c[2] && k == n - 1));
      if (k == stop_k) begin
        stp = 1'b1;
        @(negedge clk);
        stp = 1'b0;
        break;
      end
      @(negedge clk);
      if (!c[2] && k == n - 1) break;
    end
    chk(vld == 1'b0, {req, " R3/R7 ended"}, int'(vld), 0);
    chk(lst == 1'b0, {req, " R8 idle last"}, int'(lst), 0);
  endtask

  initial begin
    repeat (20000000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240607));
    #1;
    chk(vld == 1'b0 && lst == 1'b0, "R1 in reset", int'({vld, lst}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(vld == 1'b0 && lst == 1'b0, "R1 after reset", int'({vld, lst}), 0);

    // directed cases
    burst(8'h37, 3'd0, 1'b0, 1'b1, -1, "R3 len1");
    burst(8'h37, 3'd1, 1'b0, 1'b1, -1, "R4 len2 lin");
    burst(8'h36, 3'd2, 1'b0, 1'b0, -1, "R4 len4 lin");
    burst(8'h35, 3'd3, 1'b0, 1'b1, -1, "R4 len8 lin wrap");
    burst(8'h35, 3'd3, 1'b1, 1'b1, -1, "R5 len8 inter");
    burst(8'h0e, 3'd2, 1'b1, 1'b0, -1, "R5 len4 inter");
    burst(8'hfa, 3'd7, 1'b1, 1'b1, 12, "R6 full page wrap");
    burst(8'h00, 3'd4, 1'b0, 1'b0, 300, "R6 full page long");
    burst(8'h20, 3'd3, 1'b0, 1'b1, 2, "R7 stop fixed");

    // R7: stop while idle has no effect
    @(negedge clk); stp = 1'b1;
    @(negedge clk); stp = 1'b0;
    chk(vld == 1'b0, "R7 idle stop", int'(vld), 0);
    burst(8'h51, 3'd1, 1'b0, 1'b1, -1, "R7 burst after idle stop");

    // R9: restart mid-burst
    @(negedge clk);
    start = 1'b1; scol = 8'h10; lcode = 3'd3; ord = 1'b0; ap = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    chk(col == 8'h11, "R9 old beat", int'(col), 8'h11);
    start = 1'b1; scol = 8'h43; lcode = 3'd1;
    @(negedge clk); start = 1'b0;
    chk(vld && col == 8'h43 && !lst, "R9 new first", int'(col), 8'h43);
    @(negedge clk);
    chk(vld && col == 8'h42 && lst, "R9 new second", int'(col), 8'h42);
    @(negedge clk);
    chk(vld == 1'b0, "R9 new ended", int'(vld), 0);

    // R10: start and stop together during a burst
    @(negedge clk);
    start = 1'b1; scol = 8'h80; lcode = 3'd7; ord = 1'b0; ap = 1'b0;
    @(negedge clk); start = 1'b0;
    @(negedge clk);
    start = 1'b1; stp = 1'b1; scol = 8'h05; lcode = 3'd0; ap = 1'b1;
    @(negedge clk); start = 1'b0; stp = 1'b0;
    chk(vld && col == 8'h05 && lst, "R10 start wins", int'(col), 8'h05);
    @(negedge clk);
    chk(vld == 1'b0, "R10 ended", int'(vld), 0);

    // constrained random
    for (int i = 0; i < 150; i++) begin
      logic [2:0] c;
      int sk;
      c = 3'($urandom_range(0, 7));
      if (c[2]) sk = $urandom_range(0, 299);
      else if ($urandom_range(0, 3) == 0) sk = $urandom_range(0, blen(c) - 1);
      else sk = -1;
      burst(8'($urandom), c, 1'($urandom), 1'($urandom), sk, "R2-rand R4 R5 R6 R7");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule